// File: doc/BRIEF.md
# Integer ALU with Overflow and Trap Detection

This block is the integer execution unit of a 32-bit load/store core. It is purely combinational. An operation code picks one function of the two source operands `s` and `t`. The block returns a data result, a flag that tells the writeback stage to drop the register write, and a two-bit exception cause that the core's exception logic acts on.

The function set covers these operations:

- add and subtract, each in a checked form that reports signed overflow and an unchecked form that wraps silently;
- bitwise AND, OR, XOR and NOR;
- signed and unsigned set-less-than;
- the low word of a multiply;
- move-if-zero and move-if-nonzero, which may cancel their own writeback;
- six trap comparisons;
- a pass-through of `t`, used to write a link address.

Two parameters pick build variants. The first chooses how the magnitude compares are made: from the subtractor's carry, or with separate comparators. The second chooses how the low product is made: from the multiply operator, or as an explicit shift-and-add array.

Top module: `int_alu`

## Requirements
- R1: Checked add (op 1) returns s+t modulo 2^32. The cause is overflow (2'b01) exactly when s and t have the same sign bit and the sum's sign bit differs from that of s. Otherwise the cause is none (2'b00).
- R2: Checked subtract (op 3) returns s-t modulo 2^32. The cause is overflow (2'b01) exactly when s and t differ in sign and the difference's sign differs from that of s.
- R3: Unchecked add (op 2) and unchecked subtract (op 4) return the wrapped sum or difference, and their cause is always none.
- R4: AND (op 5), OR (op 6), XOR (op 7) and NOR (op 8) return the bitwise function of s and t. NOR is the inverse of s OR t.
- R5: Signed set-less-than (op 9) compares the operands as two's complement. Unsigned set-less-than (op 10) compares them as magnitudes. Both return exactly 1 or 0.
- R6: Multiply (op 11) returns the low 32 bits of the signed product s*t.
- R7: Move-if-zero (op 12) returns s with discard low when t is 0, and otherwise returns 0 with discard high. Move-if-nonzero (op 13) does the opposite. No other op raises discard.
- R8: The trap ops raise cause trap (2'b10) when their condition holds, and always return 0. Their conditions are: s>=t signed (op 14), s>=t unsigned (op 15), s<t signed (op 16), s<t unsigned (op 17), s==t (op 18) and s!=t (op 19).
- R9: Pass-through (op 20) returns t unchanged with cause none and discard low.
- R10: No-op (op 0) and every unassigned code (21 to 31) return 0 with cause none and discard low.
- R11: The cause value 2'b11 never appears, and only checked add and checked subtract produce overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 5 | Operation select code |
| opnd_s | input | 32 | First source operand |
| opnd_t | input | 32 | Second source operand |
| res | output | 32 | Operation result |
| wb_discard | output | 1 | High when the register write must be dropped |
| exc_cause | output | 2 | 00 none, 01 overflow, 10 trap |

## Verification
The arithmetic ops are driven with the overflow corners: the largest positive value plus one, two most-negative values, and minus one plus one. These separate a true signed overflow from a carry out that is harmless. Operand pairs whose signs disagree, such as all-ones against one, are run through both compare forms and all six traps, so that a signed/unsigned mix-up or an off-by-one at equality changes the answer. The conditional moves are run with t zero and non-zero. Pseudo-random operands are then swept across every code, including the unassigned ones, on two instances built with the opposite variant parameters.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int OP_W    = 5;
   localparam int CAUSE_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_NOP    = 5'd0,
      OP_ADDV   = 5'd1,
      OP_ADDW   = 5'd2,
      OP_SUBV   = 5'd3,
      OP_SUBW   = 5'd4,
      OP_AND    = 5'd5,
      OP_OR     = 5'd6,
      OP_XOR    = 5'd7,
      OP_NOR    = 5'd8,
      OP_LTS    = 5'd9,
      OP_LTU    = 5'd10,
      OP_MULLO  = 5'd11,
      OP_MOVZ   = 5'd12,
      OP_MOVN   = 5'd13,
      OP_TRGES  = 5'd14,
      OP_TRGEU  = 5'd15,
      OP_TRLTS  = 5'd16,
      OP_TRLTU  = 5'd17,
      OP_TREQ   = 5'd18,
      OP_TRNE   = 5'd19,
      OP_PASST  = 5'd20
   } alu_op_e;

   localparam logic [OP_W-1:0] OP_LAST = 5'd20;

   typedef enum logic [CAUSE_W-1:0] {
      EXC_NONE = 2'b00,
      EXC_OVF  = 2'b01,
      EXC_TRAP = 2'b10
   } exc_cause_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W            = 32,
   parameter bit CMP_FROM_SUB = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic [W-1:0] diff,
   output logic         add_ovf,
   output logic         sub_ovf,
   output logic         lt_s,
   output logic         lt_u,
   output logic         eq
);
   localparam int MSB = W - 1;

   logic carry_out;

   if (W < 2) begin : g_bad_w
      $error("alu_addsub: W must be at least 2");
   end

   assign sum                 = a + b;
   assign {carry_out, diff}   = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
   assign add_ovf             = ~(a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]);
   assign sub_ovf             = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);

   generate
      if (CMP_FROM_SUB) begin : g_cmp_shared
         assign lt_u = ~carry_out;
         assign lt_s = diff[MSB] ^ sub_ovf;
         assign eq   = (diff == '0);
      end else begin : g_cmp_direct
         assign lt_u = (a < b);
         assign lt_s = ($signed(a) < $signed(b));
         assign eq   = (a == b);
      end
   endgenerate

   // widened reference sums, used only by the checks below
   logic [W:0] wide_add, wide_sub;
   assign wide_add = {a[MSB], a} + {b[MSB], b};
   assign wide_sub = {a[MSB], a} - {b[MSB], b};

   always_comb begin
      if (!$isunknown({a, b})) begin
         assert_add_ovf_R1: assert (add_ovf == (wide_add[W] != wide_add[MSB]))
            else $error("add overflow flag disagrees with widened sum");
         assert_sub_ovf_R2: assert (sub_ovf == (wide_sub[W] != wide_sub[MSB]))
            else $error("sub overflow flag disagrees with widened difference");
         assert_cmp_R5: assert ((lt_u == (a < b)) && (lt_s == ($signed(a) < $signed(b))))
            else $error("compare flags disagree with magnitude order");
      end
   end

endmodule

// File: rtl/alu_logic_mul.sv
module alu_logic_mul #(
   parameter int W         = 32,
   parameter int MUL_STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] f_and,
   output logic [W-1:0] f_or,
   output logic [W-1:0] f_xor,
   output logic [W-1:0] f_nor,
   output logic [W-1:0] mul_lo
);
   if ((MUL_STYLE != 0) && (MUL_STYLE != 1)) begin : g_bad_style
      $error("alu_logic_mul: MUL_STYLE must be 0 or 1");
   end

   assign f_and = a & b;
   assign f_or  = a | b;
   assign f_xor = a ^ b;
   assign f_nor = ~f_or;

   generate
      if (MUL_STYLE == 0) begin : g_mul_op
         // low word is identical for signed and unsigned operands
         assign mul_lo = a * b;
      end else begin : g_mul_array
         logic [W-1:0] pp [W];
         for (genvar gi = 0; gi < W; gi++) begin : g_pp
            assign pp[gi] = b[gi] ? (a << gi) : '0;
         end
         always_comb begin
            mul_lo = '0;
            for (int i = 0; i < W; i++) mul_lo = mul_lo + pp[i];
         end
         logic [W-1:0] ref_lo;
         assign ref_lo = a * b;
         always_comb begin
            if (!$isunknown({a, b})) begin
               assert_mul_low_R6: assert (mul_lo == ref_lo)
                  else $error("shift-add product differs from reference low word");
            end
         end
      end
   endgenerate

endmodule

// File: rtl/alu_cond.sv
module alu_cond #(
   parameter int W = 32
) (
   input  int_alu_pkg::alu_op_e op,
   input  logic [W-1:0]         t,
   input  logic                 lt_s,
   input  logic                 lt_u,
   input  logic                 eq,
   output logic                 t_zero,
   output logic                 trap_hit
);
   import int_alu_pkg::*;

   assign t_zero = (t == '0);

   always_comb begin
      unique case (op)
         OP_TRGES: trap_hit = ~lt_s;
         OP_TRGEU: trap_hit = ~lt_u;
         OP_TRLTS: trap_hit = lt_s;
         OP_TRLTU: trap_hit = lt_u;
         OP_TREQ:  trap_hit = eq;
         OP_TRNE:  trap_hit = ~eq;
         default:  trap_hit = 1'b0;
      endcase
   end

   always_comb begin
      if (!$isunknown({op, lt_s, lt_u, eq})) begin
         assert_trap_pair_R8: assert (!((op == OP_TREQ) && trap_hit && lt_u))
            else $error("equality trap fired while operands are ordered");
      end
   end

endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int DATA_W       = 32,
   parameter bit CMP_FROM_SUB = 1'b1,
   parameter int MUL_STYLE    = 0
) (
   input  logic [4:0]        alu_op,
   input  logic [DATA_W-1:0] opnd_s,
   input  logic [DATA_W-1:0] opnd_t,
   output logic [DATA_W-1:0] res,
   output logic              wb_discard,
   output logic [1:0]        exc_cause
);
   import int_alu_pkg::*;

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   if (DATA_W < 2) begin : g_bad_width
      $error("int_alu: DATA_W must be at least 2");
   end

   alu_op_e op;
   assign op = alu_op_e'(alu_op);

   logic [DATA_W-1:0] sum, diff, f_and, f_or, f_xor, f_nor, mul_lo;
   logic add_ovf, sub_ovf, lt_s, lt_u, eq, t_zero, trap_hit;

   alu_addsub #(.W(DATA_W), .CMP_FROM_SUB(CMP_FROM_SUB)) u_addsub (
      .a(opnd_s), .b(opnd_t), .sum(sum), .diff(diff),
      .add_ovf(add_ovf), .sub_ovf(sub_ovf),
      .lt_s(lt_s), .lt_u(lt_u), .eq(eq)
   );

   alu_logic_mul #(.W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_logic (
      .a(opnd_s), .b(opnd_t),
      .f_and(f_and), .f_or(f_or), .f_xor(f_xor), .f_nor(f_nor),
      .mul_lo(mul_lo)
   );

   alu_cond #(.W(DATA_W)) u_cond (
      .op(op), .t(opnd_t), .lt_s(lt_s), .lt_u(lt_u), .eq(eq),
      .t_zero(t_zero), .trap_hit(trap_hit)
   );

   exc_cause_e cause;

   always_comb begin
      res        = '0;
      wb_discard = 1'b0;
      cause      = EXC_NONE;
      case (op)
         OP_ADDV:  begin res = sum;  if (add_ovf) cause = EXC_OVF; end
         OP_ADDW:  res = sum;
         OP_SUBV:  begin res = diff; if (sub_ovf) cause = EXC_OVF; end
         OP_SUBW:  res = diff;
         OP_AND:   res = f_and;
         OP_OR:    res = f_or;
         OP_XOR:   res = f_xor;
         OP_NOR:   res = f_nor;
         OP_LTS:   res = lt_s ? ONE : '0;
         OP_LTU:   res = lt_u ? ONE : '0;
         OP_MULLO: res = mul_lo;
         OP_MOVZ:  if (t_zero)  res = opnd_s; else wb_discard = 1'b1;
         OP_MOVN:  if (!t_zero) res = opnd_s; else wb_discard = 1'b1;
         OP_TRGES, OP_TRGEU, OP_TRLTS, OP_TRLTU, OP_TREQ, OP_TRNE:
                   if (trap_hit) cause = EXC_TRAP;
         OP_PASST: res = opnd_t;
         default:  ;
      endcase
   end

   assign exc_cause = cause;

   always_comb begin
      if (!$isunknown({alu_op, opnd_s, opnd_t})) begin
         assert_cause_legal_R11: assert (exc_cause != 2'b11)
            else $error("illegal cause code");
         assert_ovf_source_R11: assert ((exc_cause != EXC_OVF) || (op == OP_ADDV) || (op == OP_SUBV))
            else $error("overflow raised by an unchecked op");
         assert_no_overflow_R3: assert (!((op == OP_ADDW) || (op == OP_SUBW)) || (exc_cause == EXC_NONE))
            else $error("unchecked add/sub raised a cause");
         assert_trap_result_R8: assert ((exc_cause != EXC_TRAP) || (res == '0))
            else $error("trap with non-zero result");
         assert_discard_R7: assert (!wb_discard || ((res == '0) && ((op == OP_MOVZ) || (op == OP_MOVN))))
            else $error("discard outside a conditional move or with data");
         assert_unknown_R10: assert ((alu_op <= OP_LAST) || ((res == '0) && !wb_discard && (exc_cause == EXC_NONE)))
            else $error("unassigned code produced an effect");
         assert_setlt_R5: assert (!((op == OP_LTS) || (op == OP_LTU)) || (res[DATA_W-1:1] == '0))
            else $error("set-less-than result wider than one bit");
      end
   end

endmodule

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;

   typedef struct {
      logic [4:0]  op;
      logic [31:0] s;
      logic [31:0] t;
      logic [31:0] res;
      logic        disc;
      logic [1:0]  cause;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [4:0]  alu_op = '0;
   logic [31:0] opnd_s = '0, opnd_t = '0;
   logic [31:0] res_a, res_b;
   logic        disc_a, disc_b;
   logic [1:0]  cause_a, cause_b;

   int total = 0;
   int bad   = 0;
   exp_t scb[$];

   int_alu dut_i (
      .alu_op(alu_op), .opnd_s(opnd_s), .opnd_t(opnd_t),
      .res(res_a), .wb_discard(disc_a), .exc_cause(cause_a)
   );

   int_alu #(.CMP_FROM_SUB(1'b0), .MUL_STYLE(1)) dut_alt_i (
      .alu_op(alu_op), .opnd_s(opnd_s), .opnd_t(opnd_t),
      .res(res_b), .wb_discard(disc_b), .exc_cause(cause_b)
   );

   function automatic exp_t model(logic [4:0] op, logic [31:0] s, logic [31:0] t);
      exp_t e;
      longint ps;
      logic [31:0] r;
      e.op = op; e.s = s; e.t = t;
      e.res = '0; e.disc = 1'b0; e.cause = 2'b00; e.tag = "R10";
      case (op)
         5'd1: begin r = s + t; e.res = r; e.tag = "R1";
                  if (s[31] == t[31] && r[31] != s[31]) e.cause = 2'b01; end
         5'd2: begin e.res = s + t; e.tag = "R3"; end
         5'd3: begin r = s - t; e.res = r; e.tag = "R2";
                  if (s[31] != t[31] && r[31] != s[31]) e.cause = 2'b01; end
         5'd4: begin e.res = s - t; e.tag = "R3"; end
         5'd5: begin e.res = s & t; e.tag = "R4"; end
         5'd6: begin e.res = s | t; e.tag = "R4"; end
         5'd7: begin e.res = s ^ t; e.tag = "R4"; end
         5'd8: begin e.res = ~(s | t); e.tag = "R4"; end
         5'd9: begin e.res = {31'd0, $signed(s) < $signed(t)}; e.tag = "R5"; end
         5'd10: begin e.res = {31'd0, s < t}; e.tag = "R5"; end
         5'd11: begin ps = longint'($signed(s)) * longint'($signed(t));
                   e.res = ps[31:0]; e.tag = "R6"; end
         5'd12: begin e.tag = "R7"; if (t == 0) e.res = s; else e.disc = 1'b1; end
         5'd13: begin e.tag = "R7"; if (t != 0) e.res = s; else e.disc = 1'b1; end
         5'd14: begin e.tag = "R8"; if ($signed(s) >= $signed(t)) e.cause = 2'b10; end
         5'd15: begin e.tag = "R8"; if (s >= t) e.cause = 2'b10; end
         5'd16: begin e.tag = "R8"; if ($signed(s) < $signed(t)) e.cause = 2'b10; end
         5'd17: begin e.tag = "R8"; if (s < t) e.cause = 2'b10; end
         5'd18: begin e.tag = "R8"; if (s == t) e.cause = 2'b10; end
         5'd19: begin e.tag = "R8"; if (s != t) e.cause = 2'b10; end
         5'd20: begin e.res = t; e.tag = "R9"; end
         default: ;
      endcase
      return e;
   endfunction

   // driver: apply one operation per cycle and queue its expected outcome
   task automatic drive(logic [4:0] op, logic [31:0] s, logic [31:0] t);
      @(posedge clk);
      #1;
      alu_op = op; opnd_s = s; opnd_t = t;
      scb.push_back(model(op, s, t));
   endtask

   task automatic compare(exp_t e, string inst, logic [31:0] r, logic d, logic [1:0] c);
      total++;
      if (r !== e.res || d !== e.disc || c !== e.cause) begin
         bad++;
         $display("FAIL %s %s op=%0d s=%h t=%h: got res=%h disc=%b cause=%b, expected res=%h disc=%b cause=%b",
                  e.tag, inst, e.op, e.s, e.t, r, d, c, e.res, e.disc, e.cause);
      end
   endtask

   // monitor: pop and compare halfway through the cycle
   always @(negedge clk) begin
      if (!rst && scb.size() > 0) begin
         exp_t e;
         e = scb.pop_front();
         compare(e, "dut_i", res_a, disc_a, cause_a);
         compare(e, "dut_alt_i", res_b, disc_b, cause_b);
      end
   end

   function automatic logic [31:0] xs(logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      logic [31:0] seed;
      // idle state: no-op with zero operands gives zero everywhere (R10)
      #2;
      total++;
      if (res_a !== 32'd0 || disc_a !== 1'b0 || cause_a !== 2'b00) begin
         bad++;
         $display("FAIL R10 idle: got res=%h disc=%b cause=%b, expected 0 0 00", res_a, disc_a, cause_a);
      end
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1 checked add corners
      drive(5'd1, 32'h7fffffff, 32'h00000001);
      drive(5'd1, 32'h80000000, 32'h80000000);
      drive(5'd1, 32'hffffffff, 32'h00000001);
      drive(5'd1, 32'h00001234, 32'h00004321);
      // R2 checked subtract corners
      drive(5'd3, 32'h80000000, 32'h00000001);
      drive(5'd3, 32'h7fffffff, 32'hffffffff);
      drive(5'd3, 32'h00000005, 32'h00000007);
      drive(5'd3, 32'h80000000, 32'h80000000);
      // R3 unchecked forms never raise
      drive(5'd2, 32'h7fffffff, 32'h00000001);
      drive(5'd4, 32'h80000000, 32'h00000001);
      // R4 logic
      drive(5'd5, 32'hf0f0a5a5, 32'hff00ff00);
      drive(5'd6, 32'hf0f0a5a5, 32'h0f000000);
      drive(5'd7, 32'hf0f0a5a5, 32'hffffffff);
      drive(5'd8, 32'h00000000, 32'h00000000);
      // R5 signed vs unsigned compare
      drive(5'd9,  32'hffffffff, 32'h00000001);
      drive(5'd10, 32'hffffffff, 32'h00000001);
      drive(5'd9,  32'h00000003, 32'h00000003);
      drive(5'd10, 32'h00000002, 32'h00000003);
      // R6 multiply low word
      drive(5'd11, 32'hffffffff, 32'h00000002);
      drive(5'd11, 32'h00010000, 32'h00010000);
      drive(5'd11, 32'h80000000, 32'hffffffff);
      // R7 conditional moves
      drive(5'd12, 32'hdeadbeef, 32'h00000000);
      drive(5'd12, 32'hdeadbeef, 32'h00000005);
      drive(5'd13, 32'hcafef00d, 32'h00000000);
      drive(5'd13, 32'hcafef00d, 32'h80000000);
      // R8 traps around equality and sign disagreement
      for (int k = 14; k <= 19; k++) begin
         drive(5'(k), 32'hffffffff, 32'h00000001);
         drive(5'(k), 32'h00000042, 32'h00000042);
         drive(5'(k), 32'h00000001, 32'hffffffff);
      end
      // R9 pass-through
      drive(5'd20, 32'h11111111, 32'h89abcdef);
      // R10 no-op and unassigned codes; R11 legal causes throughout
      drive(5'd0, 32'hffffffff, 32'hffffffff);
      drive(5'd21, 32'h7fffffff, 32'h00000001);
      drive(5'd31, 32'h80000000, 32'h80000000);

      // pseudo-random sweep over every code
      seed = 32'h1badb002;
      for (int i = 0; i < 640; i++) begin
         logic [31:0] a, b;
         seed = xs(seed); a = seed;
         seed = xs(seed); b = seed;
         if (i % 7 == 0) b = 32'd0;
         if (i % 11 == 0) b = a;
         drive(5'(i % 32), a, b);
      end

      repeat (3) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule